// File: doc/BRIEF.md
# Markov Correlation Miss Prefetcher

This block learns which cache-miss address tends to come right after another. It watches a stream of miss addresses and stores each observed transition in a direct-mapped successor table. The table is indexed by the low bits of the miss address and tagged with the remaining bits. Each table line keeps a short list of successors, ordered from the most recently seen to the least recently seen.

Each accepted miss does two things. First, the line of the previous miss is updated so that the new address becomes its newest successor. Second, the line of the current address is read, and every successor stored there is sent out as a prefetch request. Requests leave on a valid/ready stream, newest successor first. While a successor list is still being sent, no new miss is accepted.

Top module: `mkv_miss_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is 0, `miss_ready` is 1, and every table line is empty, so any miss issues no prefetch.
- R2: Reset clears the previous-miss register. The first miss accepted after reset links no predecessor to that address.
- R3: A miss whose line holds another tag, or holds nothing, issues no prefetch. That line is then rewritten as an empty line owned by the current address.
- R4: A miss that hits a line with successors puts the first one on `pf_addr`, with `pf_valid` high, in the cycle after the miss is accepted. The remaining successors follow one per accepted handshake, newest first.
- R5: A successor not yet in the list is inserted at the front, and the older entries move back one place. When all `NSUCC` (default 2) slots are full, the oldest entry is dropped.
- R6: A successor already in the list moves to the front. The others keep their relative order, and no address appears twice.
- R7: While a prefetch list is pending, `miss_ready` is 0. While `pf_ready` is 0, `pf_valid` stays high and `pf_addr` holds steady.
- R8: The index is bits [IDX_W-1:0] of the address (IDX_W defaults to 3), and the tag is the remaining upper bits. If the previous and current misses map to the same line with different tags, the empty line for the current address wins and the update is dropped. A miss that repeats the previous address records itself as its own successor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss address is offered |
| miss_ready | output | 1 | The block can accept a miss |
| miss_addr | input | ADDR_W | Line address of the miss |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | The consumer takes the prefetch address |
| pf_addr | output | ADDR_W | Predicted line address |

## Verification
The bench trains successor lists to full depth and then checks the eviction order and the move-to-front on a repeated successor. A design that kept duplicates, or dropped the wrong slot, would issue the wrong pair or the wrong order.

It sends a miss while the consumer stalls a list. A design that accepted that miss early, or let `pf_addr` change under stall, would lose or reorder requests.

It sends two addresses that share an index, and it repeats the same address twice in a row. Both cases exercise the collision priority rule.

It also resets right after a miss. A design that kept the previous address across reset would create a link that later shows up as an extra prefetch.

// File: rtl/mkv_pkg.sv
package mkv_pkg;
    parameter int ADDR_W = 16;
    parameter int IDX_W  = 3;
    parameter int NSUCC  = 2;

    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int CNT_W = $clog2(NSUCC + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic                    valid;
        tag_t                    tag;
        cnt_t                    nv;
        addr_t [NSUCC-1:0]       succ;
    } entry_t;

    function automatic idx_t idx_of(input addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic entry_t blank_entry(input tag_t t);
        entry_t r;
        r       = '0;
        r.valid = 1'b1;
        r.tag   = t;
        return r;
    endfunction

    // Put a at the front of the list; a repeat is moved, a new one pushes the oldest out.
    function automatic entry_t insert_succ(input entry_t e, input addr_t a);
        entry_t r;
        logic   found;
        int     pos;
        found = 1'b0;
        pos   = NSUCC - 1;
        for (int i = 0; i < NSUCC; i++) begin
            if (!found && (i < int'(e.nv)) && (e.succ[i] == a)) begin
                found = 1'b1;
                pos   = i;
            end
        end
        r         = e;
        r.succ[0] = a;
        for (int i = 1; i < NSUCC; i++) begin
            if (i <= pos) r.succ[i] = e.succ[i-1];
        end
        if (!found && (int'(e.nv) < NSUCC)) r.nv = e.nv + cnt_t'(1);
        return r;
    endfunction
endpackage

// File: rtl/mkv_succ_table.sv
module mkv_succ_table
    import mkv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idx_t   rd_a_idx,
    output entry_t rd_a,
    input  idx_t   rd_b_idx,
    output entry_t rd_b,
    input  logic   wa_en,
    input  idx_t   wa_idx,
    input  entry_t wa_data,
    input  logic   wb_en,
    input  idx_t   wb_idx,
    input  entry_t wb_data
);
    entry_t tbl [DEPTH];

    assign rd_a = tbl[rd_a_idx];
    assign rd_b = tbl[rd_b_idx];

    // Port b (allocation) is written last and so overrides port a on the same line.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else begin
            if (wa_en) tbl[wa_idx] <= wa_data;
            if (wb_en) tbl[wb_idx] <= wb_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        AST_NV_BOUND: assert property (@(posedge clk) disable iff (rst)
            int'(tbl[g].nv) <= NSUCC);   // R5
        for (genvar i = 0; i < NSUCC; i++) begin : g_i
            for (genvar j = i + 1; j < NSUCC; j++) begin : g_j
                AST_NO_DUP: assert property (@(posedge clk) disable iff (rst)
                    (tbl[g].valid && (int'(tbl[g].nv) > j)) |-> (tbl[g].succ[i] != tbl[g].succ[j]));   // R6
            end
        end
    end
endmodule

// File: rtl/mkv_pf_queue.sv
module mkv_pf_queue
    import mkv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  addr_t [NSUCC-1:0] load_list,
    input  cnt_t              load_cnt,
    output logic              pf_valid,
    input  logic              pf_ready,
    output addr_t             pf_addr
);
    addr_t slot [NSUCC];
    cnt_t  cnt;
    logic  pop;

    assign pf_valid = (cnt != '0);
    assign pf_addr  = slot[0];
    assign pop      = pf_valid && pf_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < NSUCC; i++) slot[i] <= '0;
        end else if (load) begin
            cnt <= load_cnt;
            for (int i = 0; i < NSUCC; i++) slot[i] <= load_list[i];
        end else if (pop) begin
            cnt <= cnt - cnt_t'(1);
            for (int i = 0; i < NSUCC - 1; i++) slot[i] <= slot[i+1];
        end
    end

    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt == '0));   // R7
    AST_PF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));   // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= NSUCC);   // R4
endmodule

// File: rtl/mkv_miss_prefetcher.sv
module mkv_miss_prefetcher
    import mkv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  miss_valid,
    output logic  miss_ready,
    input  addr_t miss_addr,
    output logic  pf_valid,
    input  logic  pf_ready,
    output addr_t pf_addr
);
    addr_t  prev_addr;
    logic   prev_valid;
    logic   accept;
    entry_t prev_ent, cur_ent, upd_ent;
    logic   prev_hit, cur_hit;
    logic   upd_we, alloc_we, q_load;

    assign miss_ready = !pf_valid;
    assign accept     = miss_valid && miss_ready;

    mkv_succ_table u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (idx_of(prev_addr)),
        .rd_a     (prev_ent),
        .rd_b_idx (idx_of(miss_addr)),
        .rd_b     (cur_ent),
        .wa_en    (upd_we),
        .wa_idx   (idx_of(prev_addr)),
        .wa_data  (upd_ent),
        .wb_en    (alloc_we),
        .wb_idx   (idx_of(miss_addr)),
        .wb_data  (blank_entry(tag_of(miss_addr)))
    );

    always_comb begin
        prev_hit = prev_ent.valid && (prev_ent.tag == tag_of(prev_addr));
        cur_hit  = cur_ent.valid && (cur_ent.tag == tag_of(miss_addr));
        if (prev_hit) begin
            upd_ent = insert_succ(prev_ent, miss_addr);
        end else begin
            upd_ent = insert_succ(blank_entry(tag_of(prev_addr)), miss_addr);
        end
        upd_we   = accept && prev_valid;
        alloc_we = accept && !cur_hit;
        q_load   = accept && cur_hit && (cur_ent.nv != '0);
    end

    mkv_pf_queue u_queue (
        .clk       (clk),
        .rst       (rst),
        .load      (q_load),
        .load_list (cur_ent.succ),
        .load_cnt  (cur_ent.nv),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_addr   (pf_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr  <= '0;
            prev_valid <= 1'b0;
        end else if (accept) begin
            prev_addr  <= miss_addr;
            prev_valid <= 1'b1;
        end
    end

    AST_HIT_ISSUES: assert property (@(posedge clk) disable iff (rst)
        (accept && cur_hit && (cur_ent.nv != '0)) |=> (pf_valid && (pf_addr == $past(cur_ent.succ[0]))));   // R4
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (accept && !cur_hit) |=> !pf_valid);   // R3
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> !accept);   // R7
endmodule

// File: tb/mkv_miss_prefetcher_tb_top.sv
module mkv_miss_prefetcher_tb_top;
    import mkv_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  miss_valid = 1'b0;
    logic  miss_ready;
    addr_t miss_addr = '0;
    logic  pf_valid;
    logic  pf_ready = 1'b1;
    addr_t pf_addr;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    localparam addr_t A  = 16'h0010;
    localparam addr_t B  = 16'h0021;
    localparam addr_t C  = 16'h0032;
    localparam addr_t D  = 16'h0043;
    localparam addr_t Y  = 16'h0110;
    localparam addr_t Z  = 16'h0054;

    always #(CLK_PERIOD/2) clk = ~clk;

    mkv_miss_prefetcher dut_i (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .miss_ready (miss_ready),
        .miss_addr  (miss_addr),
        .pf_valid   (pf_valid),
        .pf_ready   (pf_ready),
        .pf_addr    (pf_addr)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        miss_valid = 1'b0;
        pf_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Send one miss, then collect the whole prefetch list and compare it.
    task automatic do_miss(input addr_t a, input int nexp, input addr_t e0,
                           input addr_t e1, input string req);
        int got;
        addr_t seen [4];
        got = 0;
        check(miss_ready == 1'b1, req, "miss_ready before miss", int'(miss_ready), 1);
        miss_valid = 1'b1;
        miss_addr  = a;
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (pf_valid) begin
                seen[got] = pf_addr;
                got++;
                @(negedge clk);
            end
        end
        check(got == nexp, req, "prefetch count", got, nexp);
        if (got == nexp && nexp > 0) check(seen[0] == e0, req, "first prefetch", int'(seen[0]), int'(e0));
        if (got == nexp && nexp > 1) check(seen[1] == e1, req, "second prefetch", int'(seen[1]), int'(e1));
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check(pf_valid == 1'b0, "R1", "pf_valid after reset", int'(pf_valid), 0);
        check(miss_ready == 1'b1, "R1", "miss_ready after reset", int'(miss_ready), 1);
    endtask

    task automatic t_learn_order();
        do_reset();
        do_miss(A, 0, '0, '0, "R1");
        do_miss(B, 0, '0, '0, "R3");
        do_miss(A, 1, B, '0, "R4");
        do_miss(C, 0, '0, '0, "R3");
        do_miss(A, 2, C, B, "R5");
        do_miss(D, 0, '0, '0, "R3");
        do_miss(A, 2, D, C, "R5");
        do_miss(C, 1, A, '0, "R4");
        do_miss(A, 2, C, D, "R6");
    endtask

    task automatic t_backpressure();
        addr_t held;
        do_reset();
        do_miss(A, 0, '0, '0, "R3");
        do_miss(B, 0, '0, '0, "R3");
        do_miss(A, 1, B, '0, "R4");
        do_miss(C, 0, '0, '0, "R3");
        pf_ready = 1'b0;
        miss_valid = 1'b1;
        miss_addr  = A;
        @(posedge clk);
        @(negedge clk);
        miss_addr = B;
        held = pf_addr;
        check(pf_valid && pf_addr == C, "R7", "stalled head", int'(pf_addr), int'(C));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(miss_ready == 1'b0, "R7", "miss_ready while draining", int'(miss_ready), 0);
            check(pf_valid && pf_addr == held, "R7", "stable under stall", int'(pf_addr), int'(held));
        end
        pf_ready = 1'b1;
        @(negedge clk);
        check(pf_valid && pf_addr == B, "R7", "second after release", int'(pf_addr), int'(B));
        check(miss_ready == 1'b0, "R7", "miss_ready on last item", int'(miss_ready), 0);
        @(negedge clk);
        check(pf_valid == 1'b0 && miss_ready == 1'b1, "R7", "idle after drain", int'(miss_ready), 1);
        @(negedge clk);
        miss_valid = 1'b0;
        check(pf_valid && pf_addr == A, "R4", "held miss issued", int'(pf_addr), int'(A));
        @(negedge clk);
        check(pf_valid == 1'b0, "R4", "single item list", int'(pf_valid), 0);
    endtask

    task automatic t_reset_prev();
        // prev holds B here; a stale link B->A would allocate B with successor A.
        do_reset();
        do_miss(A, 0, '0, '0, "R2");
        do_miss(B, 0, '0, '0, "R2");
    endtask

    task automatic t_conflict();
        do_reset();
        do_miss(A, 0, '0, '0, "R3");
        do_miss(B, 0, '0, '0, "R3");
        do_miss(A, 1, B, '0, "R4");
        do_miss(Y, 0, '0, '0, "R8");
        do_miss(A, 0, '0, '0, "R8");
        do_miss(Y, 0, '0, '0, "R8");
        do_miss(Z, 0, '0, '0, "R3");
        do_miss(Z, 0, '0, '0, "R8");
        do_miss(Z, 1, Z, '0, "R8");
    endtask

    initial begin
        t_reset_state();
        t_learn_order();
        t_backpressure();
        t_reset_prev();
        t_conflict();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R7: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule